// File: doc/BRIEF.md
# Gshare Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It holds a table of 2^G two-bit saturating counters and a G-bit global history of recent branch outcomes. A counter is chosen by XOR-ing the history with the word-aligned branch address, reduced to G bits. The fetch stage presents an address and receives a taken or not-taken guess in the same cycle. The guess is a combinational read of the table as it stands at the start of that cycle.

When branches resolve, the execute side reports each one on a separate update port. Each report carries the branch address, the real outcome and a sequence tag. Reports that arrive in the same cycle are applied one after another in ascending tag order, whatever port they arrive on. For each report, the counter is first located with the history as it stands at that point. The counter is then trained with the outcome, and only after that is the outcome shifted into the history. A later report in the same cycle therefore sees both the history and the counter values left by the earlier ones.

Top module: `gshare_predictor`

## Requirements
- R1: After reset every counter holds 2'b01 (weakly not taken) and the history is all zeros, so every address predicts not taken.
- R2: The counter used for an address A with history H is entry (A[G+1:2]) XOR H: the two low address bits are dropped, bits above G+1 are ignored, and the result is XOR-ed with the history.
- R3: `pred_taken` is 1 when the selected counter holds 2 or 3, and 0 when it holds 0 or 1.
- R4: A taken outcome raises the selected counter by one and stops at 3. A not-taken outcome lowers it by one and stops at 0.
- R5: Each applied update selects its counter with the history value before that update. The history then shifts left by one place, and the outcome enters at bit 0 (1 = taken).
- R6: Updates in one cycle are applied in ascending `upd_tag` order, independent of port number. Each one sees the history and counter values left by the update before it.
- R7: The prediction reflects the state at the start of the cycle. Updates presented in a cycle affect predictions and `hist_o` from the next cycle on.
- R8: A port whose `upd_valid` bit is 0 has no effect on any counter or on the history, whatever its address, outcome and tag inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pred_pc | input | ADDR_W | Address of the branch being fetched |
| pred_taken | output | 1 | Direction guess for `pred_pc` (1 = taken) |
| upd_valid | input | NUM_UPD | One bit per update port; 1 marks a resolved branch |
| upd_pc | input | NUM_UPD x ADDR_W | Address of each resolved branch |
| upd_taken | input | NUM_UPD | Real outcome of each resolved branch (1 = taken) |
| upd_tag | input | NUM_UPD x TAG_W | Program-order tag of each resolved branch; valid tags in a cycle are distinct |
| hist_o | output | HIST_W | Current global history register |

## Verification
The bound checker checks the history on every cycle. With no valid update it must hold (R8). With one update it must shift in exactly that outcome (R5). With several updates, the number of taken bits shifted in must match the number of taken reports (R6). The checker also checks that a lone update moves its counter one step in the right direction or holds it at a limit (R4), and that the state is correct in the first cycle after reset (R1). The bench covers what a per-cycle property cannot see. It checks the index hash and the prediction mapping over every table entry (R2, R3), and the exact bit order produced by the tag sort (R6). It also checks that a prediction taken in the same cycle as an update still sees the old state (R7).

// File: rtl/gshare_pkg.sv
`timescale 1ns/1ps
package gshare_pkg;

  localparam logic [1:0] CTR_INIT = 2'b01;
  localparam logic [1:0] CTR_MAX  = 2'b11;
  localparam logic [1:0] CTR_MIN  = 2'b00;

  // Saturating two-bit training step
  function automatic logic [1:0] ctr_train(input logic [1:0] c, input logic taken);
    logic [1:0] r;
    if (taken) r = (c == CTR_MAX) ? c : c + 2'd1;
    else       r = (c == CTR_MIN) ? c : c - 2'd1;
    return r;
  endfunction

  // Upper half of the counter range means taken
  function automatic logic ctr_says_taken(input logic [1:0] c);
    return c[1];
  endfunction

endpackage

// File: rtl/gshare_hash.sv
`timescale 1ns/1ps
module gshare_hash #(
  parameter int ADDR_W = 32,
  parameter int HIST_W = 8
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic [HIST_W-1:0] hist,
  output logic [HIST_W-1:0] idx
);
  localparam int LO = 2;
  localparam int HI = HIST_W + LO - 1;

  logic unused_pc_bits;
  assign unused_pc_bits = ^{pc[ADDR_W-1:HI+1], pc[LO-1:0]};

  assign idx = pc[HI:LO] ^ hist;
endmodule

// File: rtl/gshare_order.sv
`timescale 1ns/1ps
module gshare_order #(
  parameter int NUM_UPD = 2,
  parameter int TAG_W   = 8
) (
  input  logic [NUM_UPD-1:0]            valid,
  input  logic [NUM_UPD-1:0][TAG_W-1:0] tag,
  output logic [NUM_UPD-1:0]            slot_valid,
  output logic [NUM_UPD-1:0][((NUM_UPD > 1) ? $clog2(NUM_UPD) : 1)-1:0] slot_port
);
  localparam int PW = (NUM_UPD > 1) ? $clog2(NUM_UPD) : 1;
  localparam int RW = $clog2(NUM_UPD + 1);

  logic [RW-1:0] rank [NUM_UPD];

  // rank = number of valid reports that go before this one
  always_comb begin
    for (int i = 0; i < NUM_UPD; i++) begin
      rank[i] = '0;
      for (int j = 0; j < NUM_UPD; j++) begin
        if (j != i && valid[j] &&
            ((tag[j] < tag[i]) || ((tag[j] == tag[i]) && (j < i))))
          rank[i] = rank[i] + RW'(1);
      end
    end
  end

  always_comb begin
    for (int s = 0; s < NUM_UPD; s++) begin
      slot_valid[s] = 1'b0;
      slot_port[s]  = '0;
      for (int i = 0; i < NUM_UPD; i++) begin
        if (valid[i] && rank[i] == RW'(s)) begin
          slot_valid[s] = 1'b1;
          slot_port[s]  = PW'(i);
        end
      end
    end
  end
endmodule

// File: rtl/gshare_chain.sv
`timescale 1ns/1ps
module gshare_chain
  import gshare_pkg::*;
#(
  parameter int NUM_UPD = 2,
  parameter int ADDR_W  = 32,
  parameter int HIST_W  = 8
) (
  input  logic [(1<<HIST_W)-1:0][1:0]    ctr_q,
  input  logic [HIST_W-1:0]              hist_q,
  input  logic [NUM_UPD-1:0]             slot_valid,
  input  logic [NUM_UPD-1:0][ADDR_W-1:0] slot_pc,
  input  logic [NUM_UPD-1:0]             slot_taken,
  output logic [NUM_UPD-1:0]             wr_en,
  output logic [NUM_UPD-1:0][HIST_W-1:0] wr_idx,
  output logic [NUM_UPD-1:0][1:0]        wr_val,
  output logic [HIST_W-1:0]              hist_d
);
  function automatic logic [HIST_W-1:0] hist_push(input logic [HIST_W-1:0] h, input logic t);
    return {h[HIST_W-2:0], t};
  endfunction

  logic [HIST_W-1:0] hist_at [NUM_UPD+1];
  logic [HIST_W-1:0] idx     [NUM_UPD];

  assign hist_at[0] = hist_q;

  for (genvar k = 0; k < NUM_UPD; k++) begin : g_slot
    gshare_hash #(.ADDR_W(ADDR_W), .HIST_W(HIST_W)) u_hash (
      .pc   (slot_pc[k]),
      .hist (hist_at[k]),
      .idx  (idx[k])
    );
    assign hist_at[k+1] = slot_valid[k] ? hist_push(hist_at[k], slot_taken[k]) : hist_at[k];
    assign wr_en[k]  = slot_valid[k];
    assign wr_idx[k] = idx[k];
  end

  assign hist_d = hist_at[NUM_UPD];

  // Each slot trains the value left by earlier slots on the same entry
  always_comb begin
    logic [1:0] nv [NUM_UPD];
    logic [1:0] cur;
    for (int k = 0; k < NUM_UPD; k++) begin
      cur = ctr_q[idx[k]];
      for (int j = 0; j < k; j++) begin
        if (slot_valid[j] && idx[j] == idx[k]) cur = nv[j];
      end
      nv[k]     = ctr_train(cur, slot_taken[k]);
      wr_val[k] = nv[k];
    end
  end
endmodule

// File: rtl/gshare_predictor.sv
`timescale 1ns/1ps
module gshare_predictor
  import gshare_pkg::*;
#(
  parameter int HIST_W  = 8,
  parameter int ADDR_W  = 32,
  parameter int NUM_UPD = 2,
  parameter int TAG_W   = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [ADDR_W-1:0]              pred_pc,
  output logic                           pred_taken,
  input  logic [NUM_UPD-1:0]             upd_valid,
  input  logic [NUM_UPD-1:0][ADDR_W-1:0] upd_pc,
  input  logic [NUM_UPD-1:0]             upd_taken,
  input  logic [NUM_UPD-1:0][TAG_W-1:0]  upd_tag,
  output logic [HIST_W-1:0]              hist_o
);
  localparam int TBL = 1 << HIST_W;
  localparam int PW  = (NUM_UPD > 1) ? $clog2(NUM_UPD) : 1;

  logic [TBL-1:0][1:0] ctr_q;
  logic [HIST_W-1:0]   hist_q;

  // prediction path
  logic [HIST_W-1:0] pred_idx;
  gshare_hash #(.ADDR_W(ADDR_W), .HIST_W(HIST_W)) u_pred_hash (
    .pc   (pred_pc),
    .hist (hist_q),
    .idx  (pred_idx)
  );
  assign pred_taken = ctr_says_taken(ctr_q[pred_idx]);

  // order same-cycle reports by tag
  logic [NUM_UPD-1:0]         slot_valid;
  logic [NUM_UPD-1:0][PW-1:0] slot_port;
  gshare_order #(.NUM_UPD(NUM_UPD), .TAG_W(TAG_W)) u_order (
    .valid      (upd_valid),
    .tag        (upd_tag),
    .slot_valid (slot_valid),
    .slot_port  (slot_port)
  );

  logic [NUM_UPD-1:0][ADDR_W-1:0] slot_pc;
  logic [NUM_UPD-1:0]             slot_taken;
  for (genvar s = 0; s < NUM_UPD; s++) begin : g_mux
    assign slot_pc[s]    = upd_pc[slot_port[s]];
    assign slot_taken[s] = upd_taken[slot_port[s]];
  end

  logic [NUM_UPD-1:0]             wr_en;
  logic [NUM_UPD-1:0][HIST_W-1:0] wr_idx;
  logic [NUM_UPD-1:0][1:0]        wr_val;
  logic [HIST_W-1:0]              hist_d;
  gshare_chain #(.NUM_UPD(NUM_UPD), .ADDR_W(ADDR_W), .HIST_W(HIST_W)) u_chain (
    .ctr_q      (ctr_q),
    .hist_q     (hist_q),
    .slot_valid (slot_valid),
    .slot_pc    (slot_pc),
    .slot_taken (slot_taken),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_val     (wr_val),
    .hist_d     (hist_d)
  );

  // named events for the checker
  logic              first_valid;
  logic [HIST_W-1:0] first_idx;
  logic              first_taken;
  assign first_valid = wr_en[0];
  assign first_idx   = wr_idx[0];
  assign first_taken = slot_taken[0];

  // later slots override earlier ones on the same entry
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < TBL; e++) ctr_q[e] <= CTR_INIT;
      hist_q <= '0;
    end else begin
      for (int k = 0; k < NUM_UPD; k++) begin
        if (wr_en[k]) ctr_q[wr_idx[k]] <= wr_val[k];
      end
      hist_q <= hist_d;
    end
  end

  assign hist_o = hist_q;
endmodule

// File: rtl/gshare_predictor_chk.sv
`timescale 1ns/1ps
module gshare_predictor_chk #(
  parameter int HIST_W  = 8,
  parameter int NUM_UPD = 2
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [NUM_UPD-1:0]           upd_valid,
  input logic [NUM_UPD-1:0]           upd_taken,
  input logic [HIST_W-1:0]            hist_o,
  input logic [(1<<HIST_W)-1:0][1:0]  ctr_q,
  input logic                         first_valid,
  input logic [HIST_W-1:0]            first_idx,
  input logic                         first_taken
);
  function automatic logic [HIST_W-1:0] low_mask(input int n);
    logic [HIST_W-1:0] m;
    m = '0;
    for (int b = 0; b < HIST_W; b++) if (b < n) m[b] = 1'b1;
    return m;
  endfunction

  int nv, nt;
  assign nv = $countones(upd_valid);
  assign nt = $countones(upd_valid & upd_taken);

  logic was_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) was_rst <= 1'b1;
    else        was_rst <= 1'b0;
  end

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    was_rst |-> (hist_o == '0 && ctr_q[0] == 2'b01));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nv == 0) |=> (hist_o == $past(hist_o)));

  // R5
  hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nv == 1) |=> (hist_o == HIST_W'(({1'b0, $past(hist_o)} << 1) | (HIST_W+1)'($past(nt)))));

  // R6
  multi_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nv > 1 && nv <= HIST_W) |=> ($countones(hist_o & low_mask($past(nv))) == $past(nt)));

  // R4
  ctr_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nv == 1 && first_valid && first_taken) |=>
      (ctr_q[$past(first_idx)] >= $past(ctr_q[first_idx]) &&
       (ctr_q[$past(first_idx)] != $past(ctr_q[first_idx]) || $past(ctr_q[first_idx]) == 2'd3)));

  // R4
  ctr_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nv == 1 && first_valid && !first_taken) |=>
      (ctr_q[$past(first_idx)] <= $past(ctr_q[first_idx]) &&
       (ctr_q[$past(first_idx)] != $past(ctr_q[first_idx]) || $past(ctr_q[first_idx]) == 2'd0)));
endmodule

bind gshare_predictor gshare_predictor_chk #(.HIST_W(HIST_W), .NUM_UPD(NUM_UPD)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .upd_valid   (upd_valid),
  .upd_taken   (upd_taken),
  .hist_o      (hist_o),
  .ctr_q       (ctr_q),
  .first_valid (first_valid),
  .first_idx   (first_idx),
  .first_taken (first_taken)
);

// File: tb/gshare_predictor_bench.sv
`timescale 1ns/1ps
module gshare_predictor_bench;
  localparam int G  = 4;
  localparam int N  = 3;
  localparam int AW = 16;
  localparam int TW = 6;
  localparam int ENT = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] pred_pc = '0;
  logic pred_taken;
  logic [N-1:0] upd_valid = '0;
  logic [N-1:0][AW-1:0] upd_pc = '0;
  logic [N-1:0] upd_taken = '0;
  logic [N-1:0][TW-1:0] upd_tag = '0;
  logic [G-1:0] hist_o;

  always #5 clk = ~clk;

  gshare_predictor #(.HIST_W(G), .ADDR_W(AW), .NUM_UPD(N), .TAG_W(TW)) u_gshare_predictor (
    .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pred_taken),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
    .upd_tag(upd_tag), .hist_o(hist_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  int mctr [ENT];
  int mhist;

  // staged stimulus
  logic [N-1:0]         sv;
  logic [N-1:0][AW-1:0] spc;
  logic [N-1:0]         stk;
  logic [N-1:0][TW-1:0] stg;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int m_index(input int pc);
    return ((pc >> 2) % ENT) ^ mhist;
  endfunction

  function automatic int m_pred(input int pc);
    return (mctr[m_index(pc)] >= 2) ? 1 : 0;
  endfunction

  // apply staged reports, lowest tag first
  task automatic m_apply();
    for (int t = 0; t < (1 << TW); t++) begin
      for (int i = 0; i < N; i++) begin
        if (sv[i] && int'(stg[i]) == t) begin
          int ix;
          ix = m_index(int'(spc[i]));
          if (stk[i]) mctr[ix] = (mctr[ix] == 3) ? 3 : mctr[ix] + 1;
          else        mctr[ix] = (mctr[ix] == 0) ? 0 : mctr[ix] - 1;
          mhist = ((mhist << 1) | int'(stk[i])) % ENT;
        end
      end
    end
  endtask

  // every table position, with noise in the ignored address bits
  task automatic sweep(input string req);
    for (int p = 0; p < ENT; p++) begin
      logic [AW-1:0] a;
      a = AW'($urandom);
      a[5:2] = p[3:0];
      pred_pc = a;
      #0.2;
      chk(pred_taken == m_pred(int'(a)), req, int'(pred_taken), m_pred(int'(a)));
    end
  endtask

  task automatic step(input string req, input bit pre);
    @(negedge clk);
    upd_valid = sv; upd_pc = spc; upd_taken = stk; upd_tag = stg;
    if (pre) sweep("R7");
    @(posedge clk);
    #1;
    m_apply();
    upd_valid = '0;
    chk(int'(hist_o) == mhist, req, int'(hist_o), mhist);
    sweep(req);
  endtask

  task automatic single(input int pc, input bit tk);
    sv = 3'b001; spc = '0; spc[0] = AW'(pc); stk = '0; stk[0] = tk; stg = '0;
  endtask

  task automatic finish_report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_report();
  end

  initial begin
    for (int e = 0; e < ENT; e++) mctr[e] = 1;
    mhist = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #0.5;
    // R1: reset state
    chk(hist_o == '0, "R1", int'(hist_o), 0);
    sweep("R1");

    // R4: repeated not-taken on entry 0 saturates at 0
    for (int r = 0; r < 3; r++) begin single(0, 1'b0); step("R4", 1'b0); end
    // R4: repeated taken; history reaches all ones, entry 15 saturates at 3
    for (int r = 0; r < 7; r++) begin single(0, 1'b1); step("R4", 1'b0); end

    // R2: upper-bit noise in update address; R7 pre-edge view
    single(16'hA5C6, 1'b1); step("R2", 1'b1);
    single(16'h3F0B, 1'b0); step("R2", 1'b1);

    // R6: tags reversed against port order
    sv = 3'b011; spc = '0; spc[0] = 16'h0010; spc[1] = 16'h0024;
    stk = 3'b001; stg = '0; stg[0] = 6'd9; stg[1] = 6'd3;
    step("R6", 1'b1);
    // R6: all ports on one address, scrambled tags
    sv = 3'b111; spc[0] = 16'h0008; spc[1] = 16'h0008; spc[2] = 16'h0008;
    stk = 3'b101; stg[0] = 6'd5; stg[1] = 6'd2; stg[2] = 6'd7;
    step("R6", 1'b1);
    sv = 3'b111; stk = 3'b110; stg[0] = 6'd40; stg[1] = 6'd41; stg[2] = 6'd1;
    step("R6", 1'b0);

    // R8: idle ports carrying noise
    for (int r = 0; r < 4; r++) begin
      sv = '0;
      for (int i = 0; i < N; i++) begin
        spc[i] = AW'($urandom); stk[i] = 1'($urandom); stg[i] = TW'($urandom);
      end
      step("R8", 1'b0);
    end

    // R3 R5 R6: randomized traffic
    for (int r = 0; r < 400; r++) begin
      logic [31:0] rv;
      rv = $urandom;
      sv = N'($urandom);
      for (int i = 0; i < N; i++) begin
        spc[i] = AW'($urandom);
        stk[i] = 1'($urandom);
      end
      stg[0] = rv[5:0]; stg[1] = rv[11:6]; stg[2] = rv[17:12];
      if (stg[1] == stg[0] || stg[2] == stg[0] || stg[2] == stg[1]) begin
        stg[1] = stg[0] ^ 6'd1; stg[2] = stg[0] ^ 6'd2;
      end
      if ($countones(sv) > 1) step("R6", r[0]);
      else if ($countones(sv) == 1) step("R5", r[0]);
      else step("R3", r[0]);
    end

    finish_report();
  end
endmodule